// File: doc/BRIEF.md
# Key-Protected Hardware Watchdog Timer

This block is a hardware watchdog that resets the chip when software stops servicing it. An internal down-counter, `CNT_W` bits wide, is decremented once per prescale period. The period is 2^`PRESCALE_W` system clocks. With the default of 17 the system clock is divided by 131072, which is roughly 763 Hz from a 100 MHz clock. Software controls the block with a single write strobe. The write carries a reload value, a one-bit command (start or stop) and a `KEY_W`-bit key.

Each write is accepted only when its key is the bitwise inverse of the key in the last accepted write. A program that runs away and writes the same word over and over therefore cannot keep the watchdog alive or stop it. A start write reloads the counter, so a start and a service kick are the same operation. The block warns in two steps. It sends a one-cycle non-maskable interrupt pulse when the count steps down to 1. It then raises a chip-reset request when the next period ends, and that request holds until the block's own reset.

Top module: `kwdt_top`

## Requirements
- R1: After `rst_n` is released, the watchdog is stopped, `nmi_o` and `chip_rst_o` are low, and the stored key is all zeros. The first write that can be accepted therefore carries the all-ones key (0x7F for 7 bits). While the block is stopped, neither output rises.
- R2: A write (`wr_en` high for one cycle) is accepted only if `wr_key` equals the bitwise inverse of the stored key. An accepted write's key becomes the new stored key.
- R3: A write with any other key is ignored. It leaves the count, the running state and the stored key unchanged, so the pending interrupt and reset keep their original timing and the next expected key is still the same.
- R4: An accepted write with `wr_cmd`=1 (start) loads `wr_cnt` into the counter and sets the watchdog running. The first decrement happens 2^`PRESCALE_W` clocks after the accepting edge, and each later decrement follows after another 2^`PRESCALE_W` clocks.
- R5: An accepted start while the watchdog is running reloads the count and restarts the prescaler from zero. All later events are then timed from the kick, whatever the prescaler phase was when the kick arrived.
- R6: An accepted write with `wr_cmd`=0 (stop) halts counting. No interrupt or reset follows while the watchdog stays stopped. A later accepted start resumes operation.
- R7: `nmi_o` is high for exactly one cycle when a decrement takes the count from 2 to 1. For a start value N≥2 this occurs at edge N−1 prescale periods after the start. A start value of 1 produces no interrupt pulse.
- R8: `chip_rst_o` rises when a period ends while the count is 1 or 0, which is N periods after a start with value N. It then stays high, whatever is written, until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the whole block |
| wr_en | input | 1 | Control write strobe, one cycle per write |
| wr_cnt | input | CNT_W | Reload value used by a start command |
| wr_cmd | input | 1 | Command: 1 = start/kick, 0 = stop |
| wr_key | input | KEY_W | Key; must be the inverse of the last accepted key |
| nmi_o | output | 1 | One-cycle non-maskable interrupt request when the count reaches 1 |
| chip_rst_o | output | 1 | Sticky chip-reset request when the count reaches 0 |

## Verification
The start values 2, 3, 5, 8, 1 and 255 are each run from a clean reset. The interrupt and reset times are measured in clocks from the accepting edge. These runs separate an off-by-one in the prescale period from an off-by-one in the count, and the value 1 shows that no interrupt is raised when the count is loaded at 1. A kick that arrives at a prescale phase that is not a whole number of periods shows whether the prescaler is restarted or keeps its phase. The key tests use an all-zeros first key, a repeat of the last key and an unrelated key. They separate the inverse rule from a plain equality or a free pass, and a valid kick that follows a rejected write confirms that the stored key did not move. Valid and invalid stop writes, and writes made after the reset request is raised, show that stop works only with the right key and that the reset request is sticky.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   typedef enum logic {
      KWDT_STOP  = 1'b0,
      KWDT_START = 1'b1
   } kwdt_cmd_e;
endpackage

// File: rtl/kwdt_keygate.sv
module kwdt_keygate
   import kwdt_pkg::*;
#(
   parameter int KEY_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_cmd,
   input  logic [KEY_W-1:0] wr_key,
   output logic             acc_start,
   output logic             acc_stop,
   output logic [KEY_W-1:0] key_q
);
   logic key_ok;

   // the only key that is accepted is the complement of the stored one
   assign key_ok    = wr_en && (wr_key == ~key_q);
   assign acc_start = key_ok && (kwdt_cmd_e'(wr_cmd) == KWDT_START);
   assign acc_stop  = key_ok && (kwdt_cmd_e'(wr_cmd) == KWDT_STOP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q <= '0;
      end else if (key_ok) begin
         key_q <= wr_key;
      end
   end
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
   parameter int PRESCALE_W = 17
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clr,
   output logic tick
);
   generate
      if (PRESCALE_W == 0) begin : g_direct
         // no division: every running cycle is a period end
         assign tick = run;
      end else begin : g_divide
         logic [PRESCALE_W-1:0] ps_q;

         assign tick = run && (&ps_q);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ps_q <= '0;
            end else if (clr || !run) begin
               ps_q <= '0;
            end else begin
               ps_q <= ps_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_start,
   input  logic             acc_stop,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             tick,
   output logic             run_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             nmi_q,
   output logic             bite_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         run_q  <= 1'b0;
         nmi_q  <= 1'b0;
         bite_q <= 1'b0;
      end else begin
         nmi_q <= 1'b0;
         if (acc_start) begin
            cnt_q <= ld_val;
            run_q <= 1'b1;
         end else if (acc_stop) begin
            run_q <= 1'b0;
         end else if (tick) begin
            if (cnt_q <= ONE) begin
               cnt_q  <= '0;
               bite_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - ONE;
               if (cnt_q == TWO) begin
                  nmi_q <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
   parameter int CNT_W      = 8,
   parameter int KEY_W      = 7,
   parameter int PRESCALE_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic             wr_cmd,
   input  logic [KEY_W-1:0] wr_key,
   output logic             nmi_o,
   output logic             chip_rst_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("kwdt_top: CNT_W must be at least 2");
      end
      if (KEY_W < 1) begin : g_bad_key
         $error("kwdt_top: KEY_W must be at least 1");
      end
      if (PRESCALE_W < 0 || PRESCALE_W > 30) begin : g_bad_ps
         $error("kwdt_top: PRESCALE_W must lie in 0..30");
      end
   endgenerate

   logic             acc_start;
   logic             acc_stop;
   logic [KEY_W-1:0] key_q;
   logic             run_q;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;

   kwdt_keygate #(.KEY_W(KEY_W)) u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_cmd    (wr_cmd),
      .wr_key    (wr_key),
      .acc_start (acc_start),
      .acc_stop  (acc_stop),
      .key_q     (key_q)
   );

   kwdt_prescaler #(.PRESCALE_W(PRESCALE_W)) u_ps (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_q),
      .clr   (acc_start),
      .tick  (tick)
   );

   kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_start (acc_start),
      .acc_stop  (acc_stop),
      .ld_val    (wr_cnt),
      .tick      (tick),
      .run_q     (run_q),
      .cnt_q     (cnt_q),
      .nmi_q     (nmi_o),
      .bite_q    (chip_rst_o)
   );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
   parameter int CNT_W = 8,
   parameter int KEY_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [KEY_W-1:0] wr_key,
   input logic [KEY_W-1:0] key_q,
   input logic [CNT_W-1:0] cnt_q,
   input logic             nmi_o,
   input logic             chip_rst_o
);
   p_key_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_key == ~key_q)) |=> (key_q == $past(wr_key)));

   p_key_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_key != ~key_q)) |=> (key_q == $past(key_q)));

   p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - CNT_W'(1))));

   p_nmi_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |=> !nmi_o);

   p_nmi_at_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_o |-> (cnt_q == CNT_W'(1)));

   p_rst_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst_o |=> chip_rst_o);

   p_rst_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chip_rst_o) |-> (cnt_q == '0));
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W), .KEY_W(KEY_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_key     (wr_key),
   .key_q      (key_q),
   .cnt_q      (cnt_q),
   .nmi_o      (nmi_o),
   .chip_rst_o (chip_rst_o)
);

// File: tb/tb_kwdt_top.sv
`timescale 1ns/1ps
module tb_kwdt_top;
   localparam int CNT_W = 8;
   localparam int KEY_W = 7;
   localparam int PS_W  = 4;
   localparam int T     = 1 << PS_W;   // 16 clocks per period

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [CNT_W-1:0] wr_cnt = '0;
   logic             wr_cmd = 1'b0;
   logic [KEY_W-1:0] wr_key = '0;
   logic             nmi_o;
   logic             chip_rst_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int nmi_first = -1;
   int nmi_cnt = 0;
   int rst_first = -1;
   bit done = 0;

   kwdt_top #(.CNT_W(CNT_W), .KEY_W(KEY_W), .PRESCALE_W(PS_W)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cnt(wr_cnt),
      .wr_cmd(wr_cmd), .wr_key(wr_key), .nmi_o(nmi_o), .chip_rst_o(chip_rst_o)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish, act %0d exp <150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   always @(negedge clk) begin
      if (nmi_o) begin
         nmi_cnt = nmi_cnt + 1;
         if (nmi_first < 0) nmi_first = cyc;
      end
      if (chip_rst_o && rst_first < 0) rst_first = cyc;
   end

   // vectors: start value, expected NMI delay (-1 = none), expected reset delay
   localparam int NV = 6;
   localparam int VEC [NV][3] = '{
      '{2,     16,   32},
      '{3,     32,   48},
      '{5,     64,   80},
      '{8,    112,  128},
      '{1,     -1,   16},
      '{255, 4064, 4080}
   };

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: act %0d exp %0d", tag, act, exp);
      end
   endtask

   task automatic mon_clear();
      @(posedge clk);
      #1;
      nmi_first = -1;
      nmi_cnt   = 0;
      rst_first = -1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // write sampled at one edge; returns cycle stamp of that accepting edge
   task automatic wr(input bit cmd, input int n, input int key, output int c0);
      @(negedge clk);
      wr_en  = 1'b1;
      wr_cmd = cmd;
      wr_cnt = CNT_W'(n);
      wr_key = KEY_W'(key);
      @(negedge clk);
      wr_en  = 1'b0;
      c0 = cyc;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int c0;
      int c1;
      do_reset();
      // R1 reset state
      @(negedge clk);
      chk(nmi_o == 1'b0, "R1 nmi after reset", nmi_o, 0);
      chk(chip_rst_o == 1'b0, "R1 chip_rst after reset", chip_rst_o, 0);
      mon_clear();
      idle(400);
      chk(rst_first < 0 && nmi_cnt == 0, "R1 stopped stays quiet", rst_first, -1);

      // vector table: R4 R7 R8 timing
      for (int i = 0; i < NV; i++) begin
         do_reset();
         mon_clear();
         wr(1'b1, VEC[i][0], 'h7F, c0);
         idle(VEC[i][2] + 20);
         if (VEC[i][1] < 0) begin
            chk(nmi_cnt == 0, "R7 no nmi for load 1", nmi_cnt, 0);
         end else begin
            chk(nmi_first - c0 == VEC[i][1], "R7 nmi delay", nmi_first - c0, VEC[i][1]);
            chk(nmi_cnt == 1, "R7 nmi single cycle", nmi_cnt, 1);
         end
         chk(rst_first - c0 == VEC[i][2], "R4 R8 reset delay", rst_first - c0, VEC[i][2]);
      end

      // R1 R3: zero key on first write is not the inverse of 0
      do_reset();
      mon_clear();
      wr(1'b1, 2, 'h00, c0);
      idle(200);
      chk(rst_first < 0, "R3 first write with key 0 ignored", rst_first, -1);
      wr(1'b1, 2, 'h7F, c0);
      idle(2 * T + 10);
      chk(rst_first - c0 == 2 * T, "R1 first key all ones accepted", rst_first - c0, 2 * T);

      // R5 kick at unaligned phase restarts prescaler
      do_reset();
      mon_clear();
      wr(1'b1, 4, 'h7F, c0);
      idle(39);
      wr(1'b1, 4, 'h00, c1);
      idle(4 * T + 10);
      chk(nmi_first - c1 == 3 * T, "R5 nmi timed from kick", nmi_first - c1, 3 * T);
      chk(rst_first - c1 == 4 * T, "R5 reset timed from kick", rst_first - c1, 4 * T);

      // R3 repeated key and wrong stop ignored, timing unchanged
      do_reset();
      mon_clear();
      wr(1'b1, 4, 'h7F, c0);
      idle(10);
      wr(1'b1, 10, 'h7F, c1);
      idle(5);
      wr(1'b0, 0, 'h55, c1);
      idle(4 * T + 10);
      chk(rst_first - c0 == 4 * T, "R3 bad writes ignored", rst_first - c0, 4 * T);

      // R2 R3 stored key unchanged by a rejected write
      do_reset();
      mon_clear();
      wr(1'b1, 4, 'h7F, c0);
      idle(10);
      wr(1'b1, 9, 'h2A, c1);
      idle(5);
      wr(1'b1, 4, 'h00, c1);
      idle(4 * T + 10);
      chk(rst_first - c1 == 4 * T, "R2 inverse key kick after reject", rst_first - c1, 4 * T);

      // R6 valid stop, then restart with next inverse key
      do_reset();
      mon_clear();
      wr(1'b1, 3, 'h7F, c0);
      idle(10);
      wr(1'b0, 0, 'h00, c1);
      idle(300);
      chk(rst_first < 0 && nmi_cnt == 0, "R6 stop halts", rst_first, -1);
      wr(1'b1, 2, 'h7F, c1);
      idle(2 * T + 10);
      chk(rst_first - c1 == 2 * T, "R6 restart after stop", rst_first - c1, 2 * T);

      // R6 R3 stop with stale key ignored
      do_reset();
      mon_clear();
      wr(1'b1, 3, 'h7F, c0);
      idle(10);
      wr(1'b0, 0, 'h7F, c1);
      idle(3 * T + 10);
      chk(rst_first - c0 == 3 * T, "R6 stop with bad key ignored", rst_first - c0, 3 * T);

      // R8 sticky through writes, cleared only by rst_n
      idle(100);
      chk(chip_rst_o == 1'b1, "R8 reset stays high", chip_rst_o, 1);
      wr(1'b0, 0, 'h00, c1);
      idle(50);
      chk(chip_rst_o == 1'b1, "R8 reset held after valid stop", chip_rst_o, 1);
      do_reset();
      @(negedge clk);
      chk(chip_rst_o == 1'b0, "R8 R1 cleared by rst_n", chip_rst_o, 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule